// File: doc/BRIEF.md
# Oven Occupancy Jam Monitor

This block keeps a running count of the items inside a tunnel oven. One photo-beam sensor sits at the entrance and one at the exit; each reads 1 while an item breaks its beam. A rising edge on a sensor raises a pending event flag for that sensor. The block services pending flags itself, one per clock: an entry event adds one to the occupancy count and an exit event subtracts one. Each flag is cleared as it is serviced, and both flags are checked again after every service, so events that arrive close together or at the same time are all counted.

An active-low request line shows whether any event is still pending. An active-low buzzer turns on while more items are inside than the configured limit allows, which points to a jam. After a jam has been cleared, a preset port loads a corrected count. A sticky underflow output marks an exit event that was seen while the count was already zero.

Top module: `oven_jam_monitor`

## Requirements
- R1: A 0-to-1 transition on a sensor input, sampled at a clock edge, sets that sensor's pending flag at that same edge. `req_n` is 0 in the following cycle.
- R2: `req_n` is 1 exactly when neither pending flag is set. It returns to 1 in the cycle after the last pending event has been serviced.
- R3: When the entry flag is pending, the next edge services it: the count rises by one and the flag clears. The new count is visible after that edge.
- R4: When only the exit flag is pending, the next edge services it: the count falls by one and the flag clears.
- R5: When both flags are pending, the entry event is serviced first and the exit event at the following edge. Simultaneous edges therefore give +1 and then -1 over two cycles.
- R6: A new rising edge that arrives at the same clock edge that clears its flag leaves the flag set, so that event is serviced later and is not lost.
- R7: `buzz_n` is 0 exactly when the count is greater than ALARM_LIMIT (default 4) and 1 otherwise. It changes at the same edge as the count.
- R8: After reset the count is 0, `req_n` is 1, `buzz_n` is 1 and `underflow` is 0.
- R9: An exit service at count 0 leaves the count at 0 and sets `underflow`. `underflow` stays 1 through later services until a preset.
- R10: An entry service at the maximum count (255 with CNT_W = 8) leaves the count unchanged.
- R11: While `preset_en` is 1, the count loads `preset_val` at the edge and `underflow` clears. No flag is serviced in that cycle, and pending flags stay pending until later.
- R12: A sensor that stays at 1 for several cycles produces exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sens_entry | input | 1 | Entry beam broken (1) |
| sens_exit | input | 1 | Exit beam broken (1) |
| preset_en | input | 1 | Load `preset_val` into the count |
| preset_val | input | CNT_W | Count value to load |
| req_n | output | 1 | Active-low: an event is pending |
| count | output | CNT_W | Current occupancy |
| buzz_n | output | 1 | Active-low jam buzzer |
| underflow | output | 1 | Sticky: exit event seen at count 0 |

## Verification
The bench sweeps every preset value from 0 to 255 and follows each one with an exit event and an entry event. This exposes a count that wraps at 0 or 255 instead of holding there. It also exposes a buzzer threshold that is off by one at 4/5, and an underflow flag that a preset fails to clear. Directed sequences fire both sensors at the same edge: a design without entry-first priority or without the re-check would lose one of the two events, or service the exit event first. Other sequences land a new sensor edge on the very cycle its flag is cleared, where a design that lets the clear win would drop a count. A sensor held high exposes a level-triggered design, which would count on every cycle.

// File: rtl/oven_pkg.sv
package oven_pkg;
  localparam int NUM_SENS = 2;
  localparam int IDX_IN   = 0;
  localparam int IDX_OUT  = 1;

  typedef enum logic [1:0] {
    SVC_NONE = 2'd0,
    SVC_IN   = 2'd1,
    SVC_OUT  = 2'd2
  } svc_e;
endpackage

// File: rtl/edge_flag.sv
module edge_flag (
  input  logic clk,
  input  logic rst,
  input  logic sens,
  input  logic clr,
  output logic flag
);
  logic prev_q;
  logic rise;

  assign rise = sens & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      prev_q <= sens;
      // a fresh edge wins over a clear in the same cycle
      flag   <= (flag & ~clr) | rise;
    end
  end
endmodule

// File: rtl/svc_arbiter.sv
module svc_arbiter
  import oven_pkg::*;
(
  input  logic [NUM_SENS-1:0] flags,
  input  logic                hold,
  output svc_e                svc,
  output logic [NUM_SENS-1:0] clr
);
  always_comb begin
    svc = SVC_NONE;
    clr = '0;
    if (!hold) begin
      if (flags[IDX_IN]) begin
        svc         = SVC_IN;
        clr[IDX_IN] = 1'b1;
      end else if (flags[IDX_OUT]) begin
        svc          = SVC_OUT;
        clr[IDX_OUT] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/occupancy_counter.sv
module occupancy_counter
  import oven_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ALARM_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  svc_e             svc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             buzz_n,
  output logic             uflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(ALARM_LIMIT);

  logic [CNT_W-1:0] cnt_nx;
  logic             uflow_nx;

  always_comb begin
    cnt_nx   = cnt;
    uflow_nx = uflow;
    if (load) begin
      cnt_nx   = load_val;
      uflow_nx = 1'b0;
    end else begin
      unique case (svc)
        SVC_IN:  if (cnt != CNT_MAX) cnt_nx = cnt + 1'b1;
        SVC_OUT: begin
          if (cnt == '0) uflow_nx = 1'b1;
          else           cnt_nx   = cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      uflow  <= 1'b0;
      buzz_n <= 1'b1;
    end else begin
      cnt    <= cnt_nx;
      uflow  <= uflow_nx;
      buzz_n <= ~(cnt_nx > LIMIT);
    end
  end
endmodule

// File: rtl/oven_jam_monitor.sv
module oven_jam_monitor
  import oven_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ALARM_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sens_entry,
  input  logic             sens_exit,
  input  logic             preset_en,
  input  logic [CNT_W-1:0] preset_val,
  output logic             req_n,
  output logic [CNT_W-1:0] count,
  output logic             buzz_n,
  output logic             underflow
);
  logic [NUM_SENS-1:0] sens_v;
  logic [NUM_SENS-1:0] flag_q;
  logic [NUM_SENS-1:0] clr;
  svc_e                svc;

  assign sens_v[IDX_IN]  = sens_entry;
  assign sens_v[IDX_OUT] = sens_exit;

  for (genvar i = 0; i < NUM_SENS; i++) begin : g_sens
    edge_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .sens (sens_v[i]),
      .clr  (clr[i]),
      .flag (flag_q[i])
    );
  end

  svc_arbiter u_arb (
    .flags (flag_q),
    .hold  (preset_en),
    .svc   (svc),
    .clr   (clr)
  );

  occupancy_counter #(
    .CNT_W       (CNT_W),
    .ALARM_LIMIT (ALARM_LIMIT)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .svc      (svc),
    .load     (preset_en),
    .load_val (preset_val),
    .cnt      (count),
    .buzz_n   (buzz_n),
    .uflow    (underflow)
  );

  assign req_n = ~|flag_q;
endmodule

// File: rtl/oven_jam_monitor_chk.sv
module oven_jam_monitor_chk #(
  parameter int CNT_W       = 8,
  parameter int ALARM_LIMIT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             preset_en,
  input logic [CNT_W-1:0] preset_val,
  input logic             in_flag,
  input logic             req_n,
  input logic [CNT_W-1:0] count,
  input logic             buzz_n,
  input logic             underflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(ALARM_LIMIT);

  logic pv;
  always_ff @(posedge clk) begin
    if (rst) pv <= 1'b0;
    else     pv <= 1'b1;
  end

  // R7
  buzz_limit_chk: assert property (@(posedge clk) disable iff (rst)
    pv |-> (buzz_n == (count <= LIMIT)));

  // R11
  preset_load_chk: assert property (@(posedge clk) disable iff (rst)
    pv && $past(preset_en) |-> (count == $past(preset_val)) && !underflow);

  // R9
  uflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    pv && $past(underflow) && !$past(preset_en) |-> underflow);

  // R3
  in_incr_chk: assert property (@(posedge clk) disable iff (rst)
    pv && $past(in_flag) && !$past(preset_en) && ($past(count) != CNT_MAX)
      |-> count == CNT_W'($past(count) + 1'b1));

  // R10
  in_sat_chk: assert property (@(posedge clk) disable iff (rst)
    pv && $past(in_flag) && !$past(preset_en) && ($past(count) == CNT_MAX)
      |-> count == CNT_MAX);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pv && $past(req_n) && !$past(preset_en) |-> $stable(count));
endmodule

bind oven_jam_monitor oven_jam_monitor_chk #(
  .CNT_W       (CNT_W),
  .ALARM_LIMIT (ALARM_LIMIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .preset_en  (preset_en),
  .preset_val (preset_val),
  .in_flag    (flag_q[0]),
  .req_n      (req_n),
  .count      (count),
  .buzz_n     (buzz_n),
  .underflow  (underflow)
);

// File: tb/tb_oven_jam_monitor.sv
`timescale 1ns/1ps
module tb_oven_jam_monitor;
  localparam int W = 8;
  localparam int LIM = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sens_entry = 1'b0;
  logic         sens_exit = 1'b0;
  logic         preset_en = 1'b0;
  logic [W-1:0] preset_val = '0;
  logic         req_n;
  logic [W-1:0] count;
  logic         buzz_n;
  logic         underflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  oven_jam_monitor #(.CNT_W(W), .ALARM_LIMIT(LIM)) dut (
    .clk(clk), .rst(rst), .sens_entry(sens_entry), .sens_exit(sens_exit),
    .preset_en(preset_en), .preset_val(preset_val), .req_n(req_n),
    .count(count), .buzz_n(buzz_n), .underflow(underflow)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_buzz(input int c);
    return (c > LIM) ? 0 : 1;
  endfunction

  task automatic do_preset(input int v);
    preset_en  = 1'b1;
    preset_val = W'(v);
    tick();
    preset_en  = 1'b0;
  endtask

  task automatic pulse_entry();
    sens_entry = 1'b1; tick();
    sens_entry = 1'b0; tick();
  endtask

  task automatic pulse_exit();
    sens_exit = 1'b1; tick();
    sens_exit = 1'b0; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R8 reset state
    check("R8 count", count, 0);
    check("R8 req_n", req_n, 1);
    check("R8 buzz_n", buzz_n, 1);
    check("R8 underflow", underflow, 0);

    // R1 edge sets flag, R3 service increments, R2 request released
    sens_entry = 1'b1; tick();
    check("R1 req_n low", req_n, 0);
    check("R1 count not yet", count, 0);
    tick();
    check("R3 count", count, 1);
    check("R2 req_n high", req_n, 1);
    // R12 held level gives one event
    repeat (3) tick();
    check("R12 count held", count, 1);
    check("R12 req_n", req_n, 1);
    sens_entry = 1'b0; tick();

    // R5 simultaneous edges: entry first, then exit (R4)
    sens_entry = 1'b1; sens_exit = 1'b1; tick();
    check("R5 req_n", req_n, 0);
    tick();
    check("R5 entry first", count, 2);
    check("R5 exit pending", req_n, 0);
    tick();
    check("R4 exit served", count, 1);
    check("R2 req_n after both", req_n, 1);
    sens_entry = 1'b0; sens_exit = 1'b0; tick();

    // R6 entry edge coincides with clear; R11 preset holds flag
    sens_entry = 1'b1; tick();
    preset_en = 1'b1; preset_val = 8'd3; sens_entry = 1'b0; tick();
    check("R11 preset load", count, 3);
    check("R11 flag kept", req_n, 0);
    preset_en = 1'b0; sens_entry = 1'b1; tick();
    check("R6 entry count", count, 4);
    check("R6 entry flag reset", req_n, 0);
    check("R7 buzz at 4", buzz_n, 1);
    tick();
    check("R6 second entry", count, 5);
    check("R6 req_n", req_n, 1);
    check("R7 buzz at 5", buzz_n, 0);
    sens_entry = 1'b0; tick();

    // R6 exit edge coincides with its clear
    sens_entry = 1'b1; sens_exit = 1'b1; tick();
    sens_exit = 1'b0; tick();
    check("R6 entry then", count, 6);
    sens_exit = 1'b1; tick();
    check("R6 exit count", count, 5);
    check("R6 exit flag reset", req_n, 0);
    tick();
    check("R6 second exit", count, 4);
    check("R6 req_n done", req_n, 1);
    check("R7 buzz off at 4", buzz_n, 1);
    sens_entry = 1'b0; sens_exit = 1'b0; tick();

    // R9 sticky underflow
    do_preset(0);
    pulse_exit();
    check("R9 hold zero", count, 0);
    check("R9 underflow set", underflow, 1);
    pulse_entry();
    check("R9 count after entry", count, 1);
    check("R9 underflow sticky", underflow, 1);
    do_preset(1);
    check("R11 underflow cleared", underflow, 0);

    // sweep all preset values: R4 R9 R10 R3 R7 R11
    for (int v = 0; v < 256; v++) begin
      do_preset(v);
      check("R11 sweep load", count, v);
      check("R7 sweep buzz", buzz_n, exp_buzz(v));
      pulse_exit();
      check("R4 sweep exit", count, (v == 0) ? 0 : v - 1);
      check("R9 sweep underflow", underflow, (v == 0) ? 1 : 0);
      check("R7 sweep buzz exit", buzz_n, exp_buzz((v == 0) ? 0 : v - 1));
      do_preset(v);
      pulse_entry();
      check("R10 sweep entry", count, (v == 255) ? 255 : v + 1);
      check("R7 sweep buzz entry", buzz_n, exp_buzz((v == 255) ? 255 : v + 1));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule